// File: doc/BRIEF.md
# Operating-System Tick Timer with Timestamp Counter

This block gives a processor two time sources behind a small register bus. The first is a 32-bit timestamp counter that counts up by one on every clock and can be loaded or zeroed by software. The second is a programmable tick timer that counts down from a software-chosen value and raises an interrupt when it runs out. The timer can either reload itself and fire again and again (periodic), or fire a single time and stop (one-shot). The intended tick clock is 66.666 MHz, but the logic counts plain clock cycles.

The timer's control word holds both the count and two option bits. The two least significant bits of that word are the enable bit and the one-shot select bit, so the count the timer actually uses is the word with its two low bits forced to zero. An expiry sets a sticky pending flag. The pending flag drives the interrupt line directly and stays set until software writes a one to it.

Word map on `bus_addr`:
- 0: timestamp
- 1: control word
- 2: status, where bit 0 is the pending flag
- 3: live down-count, read-only

Writes take effect on the rising clock edge at which `bus_we` is high. Reads are combinational from `bus_addr`.

Top module: `ostmr_top`

## Requirements
- R1: After synchronous reset, the timestamp, control word, live count and pending flag all read 0, and `irq` is low.
- R2: The timestamp at word 0 increases by one on every clock and wraps from 0xFFFFFFFF to 0. A write to word 0 loads the written value, so writing zero restarts it from 0.
- R3: A read of word 1 returns the control word exactly as last written, including bits 1:0, even after a one-shot expiry.
- R4: Every write to word 1 loads the live count (word 3) with the written word with bits 1:0 cleared.
- R5: While bit 0 (enable) of the control word is set, the live count falls by one per clock. Once it reaches 0, the next clock is the expiry, which sets the pending flag. A loaded value N therefore fires N+1 clocks after the write.
- R6: With bit 1 of the control word clear (periodic), each expiry reloads the live count from the control word (bits 1:0 cleared), and the timer fires again every N+1 clocks.
- R7: With bit 1 set (one-shot), the timer fires once. The live count then stays at 0 and no further expiry occurs until word 1 is written again.
- R8: Writing 0 to word 1 stops the timer. The live count reads 0 and the pending flag is not set afterwards.
- R9: Writing a word with bit 0 set to word 2 clears the pending flag. Writing a word with bit 0 clear leaves the flag unchanged.
- R10: `irq` is high exactly when the pending flag (word 2, bit 0) reads 1.
- R11: When an expiry and a clearing write to word 2 fall on the same clock, the pending flag ends up set.
- R12: A control word with a nonzero value field and bit 0 clear loads and holds the live count without counting down or firing. Rewriting the same value with bit 0 set restarts the countdown from that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Word select for read and write |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_rdata | output | 32 | Read data of the selected word |
| irq | output | 1 | Interrupt, equal to the pending flag |

## Verification
Two functions can land on the same clock edge:
- the timer's expiry, which sets the pending flag;
- software's write-one-to-clear of that flag.

The bench provokes the collision by loading a periodic value N and issuing the clearing write so that it is sampled exactly N+1 edges after the load, which is the edge of the expiry. It judges the result by reading the status word and `irq` afterwards: both must show the flag set, and the live count must already hold the reloaded value. A second clearing write one clock later must then succeed.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;

    localparam int OST_DATA_W = 32;
    localparam int OST_ADDR_W = 2;
    localparam int OST_OPT_W  = 2;
    localparam int OST_EN_BIT = 0;
    localparam int OST_OS_BIT = 1;

    typedef enum logic [OST_ADDR_W-1:0] {
        WORD_STAMP  = 2'd0,
        WORD_CTRL   = 2'd1,
        WORD_STATUS = 2'd2,
        WORD_COUNT  = 2'd3
    } ost_word_e;

    typedef struct packed {
        logic stamp;
        logic ctrl;
        logic status;
    } ost_wstrobe_t;

    // Clear the option bits to obtain the count that the timer uses.
    function automatic logic [OST_DATA_W-1:0] count_of(input logic [OST_DATA_W-1:0] w);
        logic [OST_DATA_W-1:0] r;
        r = w;
        r[OST_OPT_W-1:0] = '0;
        return r;
    endfunction

endpackage

// File: rtl/ostmr_regdec.sv
module ostmr_regdec
    import ostmr_pkg::*;
(
    input  logic                  we,
    input  logic [OST_ADDR_W-1:0] addr,
    output ost_wstrobe_t          strobe
);
    ost_word_e sel;

    always_comb begin
        sel = ost_word_e'(addr);
        strobe = '0;
        if (we) begin
            unique case (sel)
                WORD_STAMP:  strobe.stamp  = 1'b1;
                WORD_CTRL:   strobe.ctrl   = 1'b1;
                WORD_STATUS: strobe.status = 1'b1;
                WORD_COUNT:  strobe = '0;
            endcase
        end
    end
endmodule

// File: rtl/ostmr_stamp.sv
module ostmr_stamp #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] stamp
);
    always_ff @(posedge clk) begin
        if (rst)       stamp <= '0;
        else if (load) stamp <= wdata;
        else           stamp <= stamp + DW'(1);
    end

    p_stamp_inc_r2: assert property (@(posedge clk) disable iff (rst)
        !load |=> stamp == $past(stamp) + DW'(1));

    p_stamp_load_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> stamp == $past(wdata));
endmodule

// File: rtl/ostmr_tick.sv
module ostmr_tick
    import ostmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctrl_word,
    output logic [DW-1:0] count,
    output logic          fire
);
    logic running;
    logic oneshot;

    assign oneshot = ctrl_word[OST_OS_BIT];
    assign fire    = running && (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_word <= '0;
            count     <= '0;
            running   <= 1'b0;
        end else if (load) begin
            ctrl_word <= wdata;
            count     <= count_of(wdata);
            running   <= wdata[OST_EN_BIT];
        end else if (running) begin
            if (count == '0) begin
                if (oneshot) running <= 1'b0;
                else         count   <= count_of(ctrl_word);
            end else begin
                count <= count - DW'(1);
            end
        end
    end

    p_count_dec_r5: assert property (@(posedge clk) disable iff (rst)
        running && count != '0 && !load |=> count == $past(count) - DW'(1));

    p_periodic_reload_r6: assert property (@(posedge clk) disable iff (rst)
        fire && !oneshot && !load |=> count == count_of(ctrl_word));

    p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (rst)
        fire && oneshot && !load |=> !running && count == '0);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !running && !load |=> $stable(count) && $stable(ctrl_word));

    p_load_count_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> count[OST_OPT_W-1:0] == '0);
endmodule

// File: rtl/ostmr_pend.sv
module ostmr_pend (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic clr,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (rst)       pending <= 1'b0;
        else if (fire) pending <= 1'b1;
        else if (clr)  pending <= 1'b0;
    end

    p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
        fire |=> pending);

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr && !fire |=> !pending);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !clr && !fire |=> $stable(pending));
endmodule

// File: rtl/ostmr_top.sv
module ostmr_top
    import ostmr_pkg::*;
#(
    parameter int DATA_W = OST_DATA_W,
    parameter int ADDR_W = OST_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    ost_wstrobe_t      wstb;
    logic [DATA_W-1:0] stamp;
    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] count;
    logic              fire;
    logic              pending;

    ostmr_regdec u_dec (
        .we     (bus_we),
        .addr   (bus_addr),
        .strobe (wstb)
    );

    ostmr_stamp #(.DW(DATA_W)) u_stamp (
        .clk   (clk),
        .rst   (rst),
        .load  (wstb.stamp),
        .wdata (bus_wdata),
        .stamp (stamp)
    );

    ostmr_tick #(.DW(DATA_W)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .load      (wstb.ctrl),
        .wdata     (bus_wdata),
        .ctrl_word (ctrl_word),
        .count     (count),
        .fire      (fire)
    );

    ostmr_pend u_pend (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .clr     (wstb.status && bus_wdata[0]),
        .pending (pending)
    );

    assign irq = pending;

    always_comb begin
        unique case (ost_word_e'(bus_addr))
            WORD_STAMP:  bus_rdata = stamp;
            WORD_CTRL:   bus_rdata = ctrl_word;
            WORD_STATUS: bus_rdata = {{(DATA_W-1){1'b0}}, pending};
            WORD_COUNT:  bus_rdata = count;
        endcase
    end

    p_irq_clears_only_by_write_r10: assert property (@(posedge clk) disable iff (rst)
        irq && !(bus_we && bus_addr == ADDR_W'(WORD_STATUS) && bus_wdata[0]) |=> irq);
endmodule

// File: tb/ostmr_top_tb_top.sv
module ostmr_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we;
    logic [31:0] bus_rdata;
    logic        irq;
    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ostmr_top dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Called at a negedge; the write is taken at the next posedge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(2'd0, v); chk("R1 stamp", v, 0);
        rd(2'd1, v); chk("R1 ctrl", v, 0);
        rd(2'd3, v); chk("R1 count", v, 0);
        rd(2'd2, v); chk("R1 pending", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_stamp;
        logic [31:0] v;
        wr(2'd0, 32'd0); cyc(7);
        rd(2'd0, v); chk("R2 count from zero", v, 7);
        wr(2'd0, 32'd100);
        rd(2'd0, v); chk("R2 load", v, 100);
        wr(2'd0, 32'hFFFF_FFFE); cyc(3);
        rd(2'd0, v); chk("R2 wrap", v, 1);
    endtask

    task automatic t_periodic;
        logic [31:0] v;
        wr(2'd1, N | 1); cyc(N);
        rd(2'd2, v); chk("R5 not yet fired", v, 0);
        rd(2'd3, v); chk("R5 count at zero", v, 0);
        cyc(1);
        rd(2'd2, v); chk("R5 fired after N+1", v, 1);
        chk("R10 irq high", {31'd0, irq}, 1);
        rd(2'd3, v); chk("R6 reloaded", v, N);
        wr(2'd2, 32'd0);
        rd(2'd2, v); chk("R9 write zero keeps", v, 1);
        wr(2'd2, 32'hFFFF_FFFE);
        rd(2'd2, v); chk("R9 bit0 clear keeps", v, 1);
        wr(2'd2, 32'd1);
        rd(2'd2, v); chk("R9 cleared", v, 0);
        chk("R10 irq low", {31'd0, irq}, 0);
        rd(2'd3, v); chk("R5 decrement", v, N - 3);
        cyc(N - 3);
        rd(2'd2, v); chk("R6 before second fire", v, 0);
        cyc(1);
        rd(2'd2, v); chk("R6 second fire", v, 1);
        wr(2'd1, 32'd0);
        wr(2'd2, 32'd1);
    endtask

    task automatic t_collision;
        logic [31:0] v;
        wr(2'd1, N | 1); cyc(N);
        wr(2'd2, 32'd1);
        rd(2'd2, v); chk("R11 set wins", v, 1);
        chk("R11 irq", {31'd0, irq}, 1);
        rd(2'd3, v); chk("R11 count reloaded", v, N);
        wr(2'd2, 32'd1);
        rd(2'd2, v); chk("R11 later clear", v, 0);
        wr(2'd1, 32'd0);
    endtask

    task automatic t_oneshot;
        logic [31:0] v;
        wr(2'd1, N | 3); cyc(N + 1);
        rd(2'd2, v); chk("R7 fired", v, 1);
        wr(2'd2, 32'd1); cyc(3 * N);
        rd(2'd2, v); chk("R7 no refire", v, 0);
        rd(2'd3, v); chk("R7 count stays 0", v, 0);
        rd(2'd1, v); chk("R3 readback after one-shot", v, N | 3);
    endtask

    task automatic t_loadmask;
        logic [31:0] v;
        wr(2'd1, 32'h0000_0027);
        rd(2'd3, v); chk("R4 low bits cleared", v, 32'h24);
        rd(2'd1, v); chk("R3 exact readback", v, 32'h27);
        wr(2'd1, 32'hABCD_1236);
        rd(2'd1, v); chk("R3 readback", v, 32'hABCD_1236);
        rd(2'd3, v); chk("R4 count", v, 32'hABCD_1234);
        wr(2'd1, 32'd0);
    endtask

    task automatic t_stop;
        logic [31:0] v;
        wr(2'd1, N | 1); cyc(3);
        rd(2'd3, v); chk("R5 running", v, N - 3);
        wr(2'd1, 32'd0); cyc(2 * N);
        rd(2'd3, v); chk("R8 count zero", v, 0);
        rd(2'd2, v); chk("R8 no pending", v, 0);
    endtask

    task automatic t_hold;
        logic [31:0] v;
        wr(2'd1, N); cyc(3 * N);
        rd(2'd3, v); chk("R12 held", v, N);
        rd(2'd2, v); chk("R12 no fire", v, 0);
        wr(2'd1, N | 1); cyc(N + 1);
        rd(2'd2, v); chk("R12 resumed fire", v, 1);
        wr(2'd1, 32'd0);
        wr(2'd2, 32'd1);
    endtask

    initial begin
        bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; rst = 1'b1;
        cyc(3);
        rst = 1'b0;
        t_reset();
        t_stamp();
        t_periodic();
        t_collision();
        t_oneshot();
        t_loadmask();
        t_stop();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule